// File: doc/BRIEF.md
# 8-bit Compare/Capture Timer Channel

This block is one channel of an 8-bit timer. An up-counter advances on a count-enable tick and is watched by two constant registers. Register A is always a compare register. Register B is either a second compare register or, when the capture mode input is high, a capture register that takes a copy of the counter on a chosen edge of a synchronised input pin. Each compare match can act on one output pin: drive it low, drive it high, toggle it, or leave it alone. Compare match A, or an external trigger, can also be passed on as a start request for an A/D converter.

Software reaches the block through a small register bus with four byte addresses: 0 is the counter, 1 is constant A, 2 is constant B, and 3 is the control/status byte. The counter and both constants can be read and written. Three event flags in the status byte are sticky. Software clears a flag by reading the status byte while the flag is set and then writing 0 to that flag's bit. This prevents a flag from being lost when a blind write happens before software has looked at it.

Top module: `tmr8_channel`

## Requirements
- R1: After reset the counter, constant A, constant B and the status byte all read 0x00, and `cmpOut` and `adStart` are low.
- R2: On each clock with `countTick` high the counter increases by one; otherwise it holds. A bus write to address 0 loads the counter and takes priority over the tick.
- R3: A tick while the counter holds 0xFF wraps it to 0x00 and sets the overflow flag, status bit 5.
- R4: A tick while the counter equals constant A sets compare flag A, status bit 6.
- R5: With `capMode` low, a tick while the counter equals constant B sets flag B, status bit 7.
- R6: Writing 1 to status bits 7..5 has no effect. Writing 0 to a set flag with no status read since the last status write leaves the flag set.
- R7: A status read taken while a flag is 1 arms that flag. A following status write with 0 in the flag's bit clears it. Any status write disarms all flags. Bits 4..0 read back as last written.
- R8: If a flag's set event and its clearing write fall in the same clock, the flag stays set.
- R9: Status bits 1..0 select the action on compare match A, applied to `cmpOut` at the same clock edge: 00 no change, 01 drive 0, 10 drive 1, 11 toggle.
- R10: With `capMode` low, status bits 3..2 select the same actions for compare match B. When both registers match in the same clock and bits 3..2 are not 00, the B action is applied instead of the A action.
- R11: With `capMode` high, status bits 3..2 choose the capture edge of `capPin`: 00 none, 01 rising, 10 falling, 11 both. After a two-flop synchroniser, a qualifying pin change made before clock edge k copies the counter into constant B and sets flag B at edge k+2.
- R12: `adStart` is low while `trigGlobalEn` is low. While `trigGlobalEn` is high, `adStart` follows `extTrig` when status bit 4 is 0, and follows compare match A (tick with counter equal to A) when bit 4 is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Bus write strobe |
| rdEn | input | 1 | Bus read strobe (a status read arms the set flags) |
| addr | input | 2 | Register address: 0 counter, 1 A, 2 B, 3 status |
| wrData | input | 8 | Bus write data |
| rdData | output | 8 | Bus read data (combinational) |
| countTick | input | 1 | Count enable for this clock |
| capMode | input | 1 | 1 selects capture mode for register B |
| capPin | input | 1 | Asynchronous capture input |
| extTrig | input | 1 | External A/D trigger |
| trigGlobalEn | input | 1 | Global A/D trigger enable |
| cmpOut | output | 1 | Compare output pin |
| adStart | output | 1 | A/D start request |

## Verification
The hardest case to reach is a flag whose set event lands in the same clock as its clearing write. Getting there needs an armed flag, a counter parked one step before a match, and a status write issued in the very clock that carries the tick. The stimulus first arms the flags with a status read. It then moves constant B away from the counter and reloads the counter through the bus, neither of which disarms anything. Finally it issues the clearing write together with the matching tick, so one flag must clear while the other must survive. The capture edge timing is checked cycle by cycle with the counter frozen. Register B is read in each clock after the pin change, so a synchroniser that is one stage short or one stage long shows up.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int DW = 8;
  localparam int AW = 2;
  localparam int NFLAG = 3;

  typedef logic [DW-1:0] word_t;

  // register addresses
  localparam logic [AW-1:0] ADDR_CNT = 2'd0;
  localparam logic [AW-1:0] ADDR_A   = 2'd1;
  localparam logic [AW-1:0] ADDR_B   = 2'd2;
  localparam logic [AW-1:0] ADDR_CSR = 2'd3;

  // status byte: flags occupy the top NFLAG bits, {B, A, wrap}
  localparam int FLAG_LSB = DW - NFLAG;
  localparam int ADTE_BIT = 4;

  // control -> datapath
  typedef struct packed {
    logic       ldCnt;
    logic       ldA;
    logic       ldB;
    word_t      data;
    logic [1:0] actA;
    logic [1:0] selB;
  } tmrStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic hitB;
    logic hitA;
    logic wrap;
  } tmrEvent_t;
endpackage

// File: rtl/tmr8_datapath.sv
module tmr8_datapath
  import tmr8_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       countTick,
  input  logic       capMode,
  input  logic       capPin,
  input  tmrStrobe_t strobe,
  output tmrEvent_t  evt,
  output word_t      cntVal,
  output word_t      regAVal,
  output word_t      regBVal,
  output logic       cmpOut
);
  localparam int LAST = SYNC_STAGES - 1;

  word_t cntQ, regAQ, regBQ;
  logic [SYNC_STAGES-1:0] syncQ;
  logic prevQ, outQ, outNext;
  logic riseEdge, fallEdge, capHit, cmpHitA, cmpHitB;

  function automatic logic applyAct(input logic [1:0] act, input logic cur);
    case (act)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction

  // capture pin synchroniser and edge detector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], capPin};
      prevQ <= syncQ[LAST];
    end
  end

  assign riseEdge = syncQ[LAST] & ~prevQ;
  assign fallEdge = ~syncQ[LAST] & prevQ;
  assign capHit   = capMode & ((strobe.selB[0] & riseEdge) | (strobe.selB[1] & fallEdge));

  assign cmpHitA  = countTick & (cntQ == regAQ);
  assign cmpHitB  = countTick & ~capMode & (cntQ == regBQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ  <= '0;
      regAQ <= '0;
      regBQ <= '0;
    end else begin
      if (strobe.ldCnt)   cntQ <= strobe.data;
      else if (countTick) cntQ <= cntQ + 1'b1;
      if (strobe.ldA)     regAQ <= strobe.data;
      if (strobe.ldB)     regBQ <= strobe.data;
      else if (capHit)    regBQ <= cntQ;
    end
  end

  always_comb begin
    outNext = outQ;
    if (cmpHitB && strobe.selB != 2'b00) outNext = applyAct(strobe.selB, outQ);
    else if (cmpHitA)                    outNext = applyAct(strobe.actA, outQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outQ <= 1'b0;
    else       outQ <= outNext;
  end

  assign evt.hitA = cmpHitA;
  assign evt.hitB = cmpHitB | capHit;
  assign evt.wrap = countTick & (cntQ == {DW{1'b1}});
  assign cntVal   = cntQ;
  assign regAVal  = regAQ;
  assign regBVal  = regBQ;
  assign cmpOut   = outQ;
endmodule

// File: rtl/tmr8_ctrl.sv
module tmr8_ctrl
  import tmr8_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [AW-1:0] addr,
  input  word_t         wrData,
  input  tmrEvent_t     evt,
  input  word_t         cntVal,
  input  word_t         regAVal,
  input  word_t         regBVal,
  input  logic          trigGlobalEn,
  input  logic          extTrig,
  output tmrStrobe_t    strobe,
  output word_t         rdData,
  output word_t         csrVal,
  output logic          adStart
);
  logic [NFLAG-1:0] flagQ, armedQ, setEv;
  logic [FLAG_LSB-1:0] cfgQ;
  logic csrWr, csrRd;

  assign csrWr = wrEn & (addr == ADDR_CSR);
  assign csrRd = rdEn & (addr == ADDR_CSR);
  assign setEv = {evt.hitB, evt.hitA, evt.wrap};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ  <= '0;
      armedQ <= '0;
      cfgQ   <= '0;
    end else begin
      for (int i = 0; i < NFLAG; i++) begin
        if (setEv[i])
          flagQ[i] <= 1'b1;
        else if (csrWr && armedQ[i] && !wrData[FLAG_LSB+i])
          flagQ[i] <= 1'b0;
      end
      if (csrWr)      armedQ <= '0;
      else if (csrRd) armedQ <= armedQ | flagQ;
      if (csrWr)      cfgQ <= wrData[FLAG_LSB-1:0];
    end
  end

  assign csrVal = {flagQ, cfgQ};

  always_comb begin
    case (addr)
      ADDR_CNT: rdData = cntVal;
      ADDR_A:   rdData = regAVal;
      ADDR_B:   rdData = regBVal;
      default:  rdData = csrVal;
    endcase
  end

  assign strobe.ldCnt = wrEn & (addr == ADDR_CNT);
  assign strobe.ldA   = wrEn & (addr == ADDR_A);
  assign strobe.ldB   = wrEn & (addr == ADDR_B);
  assign strobe.data  = wrData;
  assign strobe.actA  = cfgQ[1:0];
  assign strobe.selB  = cfgQ[3:2];

  assign adStart = trigGlobalEn & (cfgQ[ADTE_BIT] ? evt.hitA : extTrig);
endmodule

// File: rtl/tmr8_channel.sv
module tmr8_channel
  import tmr8_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  input  logic          countTick,
  input  logic          capMode,
  input  logic          capPin,
  input  logic          extTrig,
  input  logic          trigGlobalEn,
  output logic          cmpOut,
  output logic          adStart
);
  tmrStrobe_t strobe;
  tmrEvent_t  evt;
  word_t cntVal, regAVal, regBVal, csrVal;

  tmr8_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .evt(evt), .cntVal(cntVal), .regAVal(regAVal),
    .regBVal(regBVal), .trigGlobalEn(trigGlobalEn), .extTrig(extTrig),
    .strobe(strobe), .rdData(rdData), .csrVal(csrVal), .adStart(adStart)
  );

  tmr8_datapath #(.SYNC_STAGES(SYNC_STAGES)) uPath (
    .clk(clk), .rstN(rstN), .countTick(countTick), .capMode(capMode),
    .capPin(capPin), .strobe(strobe), .evt(evt), .cntVal(cntVal),
    .regAVal(regAVal), .regBVal(regBVal), .cmpOut(cmpOut)
  );
endmodule

// File: rtl/tmr8_checker.sv
module tmr8_checker (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [1:0] addr,
  input logic       countTick,
  input logic       trigGlobalEn,
  input logic       adStart,
  input logic       cmpOut,
  input logic [7:0] cntVal,
  input logic [7:0] regAVal,
  input logic [7:0] csrVal
);
  // R2: no tick and no load keeps the counter
  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!countTick && !(wrEn && addr == 2'd0)) |=> $stable(cntVal));

  // R3: wrap to zero raises the overflow flag
  a_r3_wrap_flag: assert property (@(posedge clk) disable iff (!rstN)
    (countTick && cntVal == 8'hFF && !(wrEn && addr == 2'd0)) |=> (cntVal == 8'h00 && csrVal[5]));

  // R4: match on A raises flag A
  a_r4_match_a: assert property (@(posedge clk) disable iff (!rstN)
    (countTick && cntVal == regAVal) |=> csrVal[6]);

  // R7: a flag can only drop as the result of a status write
  a_r7_clear_by_write: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(csrVal[7:5]) & ~csrVal[7:5])) |-> $past(wrEn && addr == 2'd3));

  // R9: the pin moves only on a counting clock
  a_r9_pin_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cmpOut) |-> $past(countTick));

  // R12: global enable low blocks start requests
  a_r12_gate_off: assert property (@(posedge clk) disable iff (!rstN)
    !trigGlobalEn |-> !adStart);
endmodule

bind tmr8_channel tmr8_checker uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .countTick(countTick),
  .trigGlobalEn(trigGlobalEn), .adStart(adStart), .cmpOut(cmpOut),
  .cntVal(cntVal), .regAVal(regAVal), .csrVal(csrVal)
);

// File: tb/tb_tmr8_channel.sv
`timescale 1ns/1ps
module tb_tmr8_channel;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic countTick = 1'b0, capMode = 1'b0, capPin = 1'b0;
  logic extTrig = 1'b0, trigGlobalEn = 1'b0;
  logic cmpOut, adStart;

  int checks = 0;
  int errors = 0;
  logic chkStb = 1'b0;
  logic done = 1'b0;

  typedef struct {
    int         kind;   // 0 rdData, 1 cmpOut, 2 adStart
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  tmr8_channel dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .countTick(countTick), .capMode(capMode),
    .capPin(capPin), .extTrig(extTrig), .trigGlobalEn(trigGlobalEn),
    .cmpOut(cmpOut), .adStart(adStart)
  );

  // monitor: pops the scoreboard away from the active edge
  always @(negedge clk) begin
    if (chkStb) begin
      item_t it;
      logic [7:0] act;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty: actual none expected item");
      end else begin
        it = sb.pop_front();
        case (it.kind)
          0:       act = rdData;
          1:       act = {7'b0, cmpOut};
          default: act = {7'b0, adStart};
        endcase
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %02h expected %02h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    cyc();
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [1:0] a, input logic [7:0] e, input string r);
    rdEn = 1'b1; addr = a;
    sb.push_back('{0, e, r});
    chkStb = 1'b1;
    cyc();
    rdEn = 1'b0; chkStb = 1'b0;
  endtask

  task automatic pinChk(input int k, input logic e, input string r);
    sb.push_back('{k, {7'b0, e}, r});
    chkStb = 1'b1;
    cyc();
    chkStb = 1'b0;
  endtask

  task automatic ticks(input int n);
    countTick = 1'b1;
    repeat (n) cyc();
    countTick = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    cyc();
    // R1 reset state
    rdChk(2'd3, 8'h00, "R1 status");
    rdChk(2'd0, 8'h00, "R1 counter");
    rdChk(2'd1, 8'h00, "R1 const A");
    rdChk(2'd2, 8'h00, "R1 const B");
    pinChk(1, 1'b0, "R1 cmpOut");
    pinChk(2, 1'b0, "R1 adStart");

    // R2 counting, holding, loading
    wr(2'd1, 8'h10);
    wr(2'd2, 8'h20);
    ticks(5);
    rdChk(2'd0, 8'h05, "R2 count after 5 ticks");
    cyc(); cyc();
    rdChk(2'd0, 8'h05, "R2 hold without tick");
    wr(2'd0, 8'h0E);
    rdChk(2'd0, 8'h0E, "R2 bus load");

    // R4 / R9 match A drives pin high
    wr(2'd3, 8'h02);
    rdChk(2'd3, 8'h02, "R4 no flag before match");
    ticks(2);
    pinChk(1, 1'b0, "R9 pin before match");
    ticks(1);
    rdChk(2'd3, 8'h42, "R4 flag A set");
    pinChk(1, 1'b1, "R9 drive high");

    // R6 / R7 clearing handshake
    wr(2'd3, 8'hE2);
    wr(2'd3, 8'h02);
    rdChk(2'd3, 8'h42, "R6 R7 blind zero write keeps flag");
    wr(2'd3, 8'h02);
    rdChk(2'd3, 8'h02, "R7 read then zero clears");

    // R9 remaining actions
    wr(2'd3, 8'h03); wr(2'd0, 8'h10); ticks(1);
    pinChk(1, 1'b0, "R9 toggle");
    wr(2'd3, 8'h00); wr(2'd0, 8'h10); ticks(1);
    pinChk(1, 1'b0, "R9 no change");
    wr(2'd3, 8'h02); wr(2'd0, 8'h10); ticks(1);
    pinChk(1, 1'b1, "R9 high again");
    wr(2'd3, 8'h01); wr(2'd0, 8'h10); ticks(1);
    pinChk(1, 1'b0, "R9 drive low");

    // R3 overflow
    wr(2'd0, 8'hFE);
    ticks(1);
    rdChk(2'd3, 8'h41, "R3 no overflow at FF");
    ticks(1);
    rdChk(2'd0, 8'h00, "R3 wrapped count");
    rdChk(2'd3, 8'h61, "R3 overflow flag");
    wr(2'd3, 8'h01);
    rdChk(2'd3, 8'h01, "R7 two flags cleared");

    // R5 / R10 compare B, B wins when both match
    wr(2'd1, 8'h30); wr(2'd2, 8'h30);
    wr(2'd3, 8'h09);
    wr(2'd0, 8'h30);
    ticks(1);
    pinChk(1, 1'b1, "R10 B action wins");
    rdChk(2'd3, 8'hC9, "R5 flag B and A set");

    // R8 set beats clear: B armed and clears, A armed but re-set
    wr(2'd2, 8'h40);
    wr(2'd0, 8'h30);
    countTick = 1'b1;
    wr(2'd3, 8'h09);
    countTick = 1'b0;
    rdChk(2'd3, 8'h49, "R8 set wins, B cleared");
    pinChk(1, 1'b0, "R9 A drives low");

    // R10 B select 00 lets A act
    wr(2'd2, 8'h30); wr(2'd3, 8'h02); wr(2'd0, 8'h30);
    ticks(1);
    pinChk(1, 1'b1, "R10 A acts when B select is 00");

    // R11 capture
    capMode = 1'b1;
    wr(2'd3, 8'h04);
    rdChk(2'd3, 8'hC4, "R11 flags before capture");
    wr(2'd3, 8'h04);
    rdChk(2'd3, 8'h04, "R7 flags cleared");
    wr(2'd0, 8'h55);
    capPin = 1'b1;
    cyc();
    rdChk(2'd2, 8'h30, "R11 no capture after 1 edge");
    rdChk(2'd2, 8'h30, "R11 no capture after 2 edges");
    rdChk(2'd2, 8'h55, "R11 rising capture at third edge");
    rdChk(2'd3, 8'h84, "R11 capture sets flag B");
    wr(2'd3, 8'h04);
    wr(2'd0, 8'h66);
    capPin = 1'b0;
    repeat (4) cyc();
    rdChk(2'd2, 8'h55, "R11 falling ignored in rising mode");
    rdChk(2'd3, 8'h04, "R11 no flag without capture");
    wr(2'd3, 8'h08); wr(2'd0, 8'h77);
    capPin = 1'b1; repeat (4) cyc();
    rdChk(2'd2, 8'h55, "R11 rising ignored in falling mode");
    capPin = 1'b0; repeat (4) cyc();
    rdChk(2'd2, 8'h77, "R11 falling capture");
    wr(2'd3, 8'h0C); wr(2'd0, 8'h88);
    capPin = 1'b1; repeat (4) cyc();
    rdChk(2'd2, 8'h88, "R11 both: rising");
    wr(2'd0, 8'h99);
    capPin = 1'b0; repeat (4) cyc();
    rdChk(2'd2, 8'h99, "R11 both: falling");
    wr(2'd3, 8'h00); wr(2'd0, 8'hAA);
    capPin = 1'b1; repeat (4) cyc();
    rdChk(2'd2, 8'h99, "R11 capture disabled");
    capMode = 1'b0;

    // R12 start request gating
    extTrig = 1'b1;
    pinChk(2, 1'b0, "R12 global enable low");
    trigGlobalEn = 1'b1;
    pinChk(2, 1'b1, "R12 external trigger passes");
    wr(2'd3, 8'h10);
    pinChk(2, 1'b0, "R12 external blocked when bit4 set");
    wr(2'd0, 8'h30);
    countTick = 1'b1;
    pinChk(2, 1'b1, "R12 match A passes");
    countTick = 1'b0;
    wr(2'd3, 8'h00);
    extTrig = 1'b0;
    wr(2'd0, 8'h30);
    countTick = 1'b1;
    pinChk(2, 1'b0, "R12 match A blocked when bit4 clear");
    countTick = 1'b0;

    cyc();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end
endmodule